// File: doc/BRIEF.md
# Integrating Converter Sequencer with Offset Calibration

This block is the digital side of a dual-slope style integrating converter that digitizes a demodulated sensor current. On a start request it clears the analog integrator for one cycle, lets it integrate for a fixed number of clock cycles, then enables a constant-current discharge and counts clock cycles until an external comparator reports that the integrator output has crossed zero. The count is the conversion result, by default 10 bits wide. It saturates at full scale with an overflow flag. After each normal conversion the result is shifted out serially, most significant bit first.

The block also holds the code for a 9-bit offset-cancelling current DAC. On a calibration request, with the sensor input held at zero, it runs a successive-approximation search over the DAC code. Each trial bit is judged by a full conversion, and the search settles on the code that brings a zero input closest to mid-scale. A larger DAC code removes more current, so it gives a smaller count.

The controller is one state machine. Its states are IDLE (waiting), CLR (integrator reset, one cycle), INTEG (integration window), DISCH (discharge and count), FIN (result latched, done pulse or calibration judgement) and SHIFT (serial output). Its transitions are:
- IDLE to CLR on a start or calibration request.
- CLR to INTEG always.
- INTEG to DISCH when the window has run out.
- DISCH to FIN when the comparator goes low or the counter is full.
- FIN to SHIFT for a normal conversion.
- FIN back to CLR for the next calibration bit.
- FIN to IDLE after the last calibration bit.
- SHIFT to IDLE after the last bit.

Top module: `intadc_seq`

## Requirements
- R1: After a start or calibration request is accepted, `int_rst_o` is high for exactly one cycle. `int_en_o` is then high for exactly INT_CYC consecutive cycles (default 16), independent of the input.
- R2: `dis_en_o` follows the integration window. The result equals the number of discharge cycles observed with `cmp_i` high before the first cycle in which `cmp_i` is low. `done_o` pulses high for one cycle in the cycle after that, with `result_o` and `ovf_o` valid.
- R3: If `cmp_i` is still high in the discharge cycle where the count is 2^RES_W-1 (1023), the result is 1023 and `ovf_o` is 1. A comparator trip at exactly count 1023 gives 1023 with `ovf_o` 0.
- R4: A start or calibration request while `busy_o` is high is ignored. The running operation ends as if no request had come, and the block returns to idle.
- R5: In the cycle after `done_o`, `ser_vld_o` goes high for RES_W consecutive cycles. `ser_o` carries the result, most significant bit first, one bit per cycle. `ser_o` is 0 whenever `ser_vld_o` is low.
- R6: A calibration request in idle runs CAL_W conversions from the DAC MSB down. For each bit, the bit is set on trial and kept if the conversion result is at least mid-scale (512); otherwise it is cleared. No `done_o` and no serial output occur during calibration. The final code is the largest code whose conversion stays at or above mid-scale.
- R7: `dac_code_o` changes only during a calibration. Normal conversions leave it unchanged.
- R8: After reset the block is idle. All controls and `done_o`, `busy_o`, `ser_vld_o`, `ser_o` and `ovf_o` are 0, and `result_o` and `dac_code_o` are 0.
- R9: At most one of `int_rst_o`, `int_en_o`, `dis_en_o` and `ser_vld_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a normal conversion (taken in idle only) |
| cal_req_i | input | 1 | Start an offset calibration (taken in idle only, wins over start) |
| cmp_i | input | 1 | Comparator: high while the integrator has not crossed zero |
| int_rst_o | output | 1 | Integrator reset |
| int_en_o | output | 1 | Integrate the input current |
| dis_en_o | output | 1 | Enable the constant-current discharge |
| dac_code_o | output | CAL_W | Offset DAC code |
| result_o | output | RES_W | Last conversion count |
| ovf_o | output | 1 | Last conversion saturated |
| done_o | output | 1 | One-cycle result-valid pulse |
| busy_o | output | 1 | Operation in progress |
| ser_o | output | 1 | Serial result bit |
| ser_vld_o | output | 1 | Serial bit valid |

## Verification
The properties assume that the comparator input is a clean synchronous signal, and that the DAC code seen by the analog side is the one the block drives. The bench models the integrator as a discharge length that depends on the input and offset, less the DAC code. It drives `cmp_i` from a counter of the discharge cycles that the block has actually enabled, so the comparator never trips outside a discharge. Requests during busy are issued only in the middle of an integration window, which keeps them clear of the idle cycle where they would be taken.

// File: rtl/intadc_pkg.sv
package intadc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_INTEG,
        ST_DISCH,
        ST_FIN,
        ST_SHIFT
    } adc_state_e;
endpackage

// File: rtl/intadc_dcnt.sv
module intadc_dcnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         full_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign full_o = (cnt_q == {W{1'b1}});
endmodule

// File: rtl/intadc_sar.sv
module intadc_sar #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         begin_i,
    input  logic         judge_i,
    input  logic         keep_i,
    output logic [W-1:0] code_o,
    output logic         last_o
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  code_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            idx_q  <= '0;
        end else if (begin_i) begin
            code_q <= {1'b1, {(W-1){1'b0}}};
            idx_q  <= IW'(W-1);
        end else if (judge_i) begin
            code_q[idx_q] <= keep_i;
            if (idx_q != '0) begin
                code_q[idx_q-1'b1] <= 1'b1;
                idx_q              <= idx_q - 1'b1;
            end
        end
    end

    assign code_o = code_q;
    assign last_o = (idx_q == '0);
endmodule

// File: rtl/intadc_ser.sv
module intadc_ser #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         shift_i,
    output logic         msb_o
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sh_q <= '0;
        else if (load_i)  sh_q <= data_i;
        else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
    end

    assign msb_o = sh_q[W-1];
endmodule

// File: rtl/intadc_seq.sv
module intadc_seq
    import intadc_pkg::*;
#(
    parameter int RES_W   = 10,
    parameter int CAL_W   = 9,
    parameter int INT_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cal_req_i,
    input  logic             cmp_i,
    output logic             int_rst_o,
    output logic             int_en_o,
    output logic             dis_en_o,
    output logic [CAL_W-1:0] dac_code_o,
    output logic [RES_W-1:0] result_o,
    output logic             ovf_o,
    output logic             done_o,
    output logic             busy_o,
    output logic             ser_o,
    output logic             ser_vld_o
);
    localparam int PH_MAX = (INT_CYC > RES_W) ? INT_CYC : RES_W;
    localparam int PH_W   = $clog2(PH_MAX) + 1;
    localparam logic [RES_W-1:0] MID  = {1'b1, {(RES_W-1){1'b0}}};
    localparam logic [RES_W-1:0] FULL = {RES_W{1'b1}};
    localparam logic [PH_W-1:0] INT_END = PH_W'(INT_CYC - 1);
    localparam logic [PH_W-1:0] SER_END = PH_W'(RES_W - 1);

    adc_state_e       state_q, state_d;
    logic             cal_q;
    logic [PH_W-1:0]  ph_q;
    logic [RES_W-1:0] res_q;
    logic             ovf_q;

    logic [RES_W-1:0] cnt;
    logic             cnt_full;
    logic             sar_last;
    logic             ser_msb;

    logic in_idle, in_clr, in_integ, in_disch, in_fin, in_shift;
    assign in_idle  = (state_q == ST_IDLE);
    assign in_clr   = (state_q == ST_CLR);
    assign in_integ = (state_q == ST_INTEG);
    assign in_disch = (state_q == ST_DISCH);
    assign in_fin   = (state_q == ST_FIN);
    assign in_shift = (state_q == ST_SHIFT);

    intadc_dcnt #(.W(RES_W)) i_dcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (in_clr),
        .inc_i  (in_disch && cmp_i && !cnt_full),
        .cnt_o  (cnt),
        .full_o (cnt_full)
    );

    intadc_sar #(.W(CAL_W)) i_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .begin_i (in_idle && cal_req_i),
        .judge_i (in_fin && cal_q),
        .keep_i  (res_q >= MID),
        .code_o  (dac_code_o),
        .last_o  (sar_last)
    );

    intadc_ser #(.W(RES_W)) i_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (in_fin && !cal_q),
        .data_i  (res_q),
        .shift_i (in_shift),
        .msb_o   (ser_msb)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cal_req_i || start_i) state_d = ST_CLR;
            ST_CLR:   state_d = ST_INTEG;
            ST_INTEG: if (ph_q == INT_END) state_d = ST_DISCH;
            ST_DISCH: if (!cmp_i || cnt_full) state_d = ST_FIN;
            ST_FIN: begin
                if (!cal_q)       state_d = ST_SHIFT;
                else if (sar_last) state_d = ST_IDLE;
                else              state_d = ST_CLR;
            end
            ST_SHIFT: if (ph_q == SER_END) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q <= 1'b0;
            ph_q  <= '0;
            res_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (in_idle) begin
                if (cal_req_i)    cal_q <= 1'b1;
                else if (start_i) cal_q <= 1'b0;
            end
            if (in_clr || in_fin)       ph_q <= '0;
            else if (in_integ || in_shift) ph_q <= ph_q + 1'b1;
            if (in_disch) begin
                if (!cmp_i) begin
                    res_q <= cnt;
                    ovf_q <= 1'b0;
                end else if (cnt_full) begin
                    res_q <= FULL;
                    ovf_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        int_rst_o = in_clr;
        int_en_o  = in_integ;
        dis_en_o  = in_disch;
        done_o    = in_fin && !cal_q;
        busy_o    = !in_idle;
        ser_vld_o = in_shift;
        ser_o     = in_shift && ser_msb;
        result_o  = res_q;
        ovf_o     = ovf_q;
    end
endmodule

// File: rtl/intadc_seq_chk.sv
module intadc_seq_chk #(
    parameter int RES_W   = 10,
    parameter int CAL_W   = 9,
    parameter int INT_CYC = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_rst_o,
    input logic             int_en_o,
    input logic             dis_en_o,
    input logic [CAL_W-1:0] dac_code_o,
    input logic [RES_W-1:0] result_o,
    input logic             ovf_o,
    input logic             done_o,
    input logic             ser_o,
    input logic             ser_vld_o
);
    int unsigned win_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        win_cnt <= 0;
        else if (int_en_o) win_cnt <= win_cnt + 1;
        else               win_cnt <= 0;
    end

    // R1
    integ_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en_o && $past(int_en_o)) |-> (win_cnt == INT_CYC));

    // R1
    clear_then_integ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst_o |=> int_en_o);

    // R2
    done_after_disch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(dis_en_o) && !dis_en_o));

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (result_o == {RES_W{1'b1}}));

    // R5
    ser_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> ser_vld_o);

    // R5
    ser_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_vld_o |-> !ser_o);

    // R7
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_en_o || ser_vld_o) |-> $stable(dac_code_o));

    // R9
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_rst_o, int_en_o, dis_en_o, ser_vld_o}));
endmodule

bind intadc_seq intadc_seq_chk #(
    .RES_W   (RES_W),
    .CAL_W   (CAL_W),
    .INT_CYC (INT_CYC)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_rst_o  (int_rst_o),
    .int_en_o   (int_en_o),
    .dis_en_o   (dis_en_o),
    .dac_code_o (dac_code_o),
    .result_o   (result_o),
    .ovf_o      (ovf_o),
    .done_o     (done_o),
    .ser_o      (ser_o),
    .ser_vld_o  (ser_vld_o)
);

// File: tb/test_intadc_seq.sv
module test_intadc_seq;
    localparam int CLK_PERIOD = 10;
    localparam int RES_W   = 10;
    localparam int CAL_W   = 9;
    localparam int INT_CYC = 16;
    localparam int FULLV   = (1 << RES_W) - 1;
    localparam int MIDV    = 1 << (RES_W - 1);
    localparam int HALFDAC = 1 << (CAL_W - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, cal_req_i = 1'b0, cmp_i;
    logic int_rst_o, int_en_o, dis_en_o, ovf_o, done_o, busy_o, ser_o, ser_vld_o;
    logic [CAL_W-1:0] dac_code_o;
    logic [RES_W-1:0] result_o;

    int n_chk = 0, n_bad = 0;
    int sig = 0, off = 0;
    int tgt;
    int dcnt = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intadc_seq #(.RES_W(RES_W), .CAL_W(CAL_W), .INT_CYC(INT_CYC)) i_intadc_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cal_req_i(cal_req_i), .cmp_i(cmp_i),
        .int_rst_o(int_rst_o), .int_en_o(int_en_o), .dis_en_o(dis_en_o),
        .dac_code_o(dac_code_o), .result_o(result_o), .ovf_o(ovf_o), .done_o(done_o),
        .busy_o(busy_o), .ser_o(ser_o), .ser_vld_o(ser_vld_o)
    );

    // integrator/comparator model: discharge length falls with the DAC code
    always_comb begin
        tgt = sig + MIDV + off + HALFDAC - int'(dac_code_o);
        if (tgt < 0) tgt = 0;
        cmp_i = (dcnt < tgt);
    end

    always @(posedge clk) begin
        dcnt <= dis_en_o ? dcnt + 1 : 0;
        cyc  <= cyc + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // one normal conversion with discharge length t; poke_busy issues requests mid-window
    task automatic convert(input int t, input bit poke_busy);
        int n_rst = 0, n_int = 0, n_dis = 0, word = 0, nbits = 0, idle_after = 0;
        int exp_res, exp_ovf;
        logic [CAL_W-1:0] code0;
        code0 = dac_code_o;
        sig = t - MIDV - off - HALFDAC + int'(dac_code_o);
        exp_res = (t > FULLV) ? FULLV : t;
        exp_ovf = (t > FULLV) ? 1 : 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (!done_o) begin
            if (int_rst_o) n_rst++;
            if (int_en_o) n_int++;
            if (dis_en_o) n_dis++;
            if (poke_busy && n_int == 5) begin
                start_i = 1'b1;
                cal_req_i = 1'b1;
            end else begin
                start_i = 1'b0;
                cal_req_i = 1'b0;
            end
            @(negedge clk);
        end
        check("R1 clear cycles", n_rst, 1);
        check("R1 integrate cycles", n_int, INT_CYC);
        check("R2 result", int'(result_o), exp_res);
        check("R3 overflow flag", int'(ovf_o), exp_ovf);
        if (t <= FULLV) check("R2 discharge cycles", n_dis, t + 1);
        @(negedge clk);
        check("R2 done width", int'(done_o), 0);
        while (ser_vld_o && nbits < RES_W + 2) begin
            word = (word << 1) | int'(ser_o);
            nbits++;
            @(negedge clk);
        end
        check("R5 serial bit count", nbits, RES_W);
        check("R5 serial word MSB first", word, exp_res);
        for (int k = 0; k < 4; k++) begin
            if (!busy_o && !ser_o && !int_rst_o) idle_after++;
            @(negedge clk);
        end
        if (poke_busy) check("R4 request while busy ignored", idle_after, 4);
        check("R7 DAC code kept", int'(dac_code_o), int'(code0));
    endtask

    task automatic calibrate(input int o);
        int n_done = 0, n_ser = 0, exp_code;
        off = o;
        sig = 0;
        exp_code = o + HALFDAC;
        if (exp_code < 0) exp_code = 0;
        if (exp_code > (1 << CAL_W) - 1) exp_code = (1 << CAL_W) - 1;
        @(negedge clk) cal_req_i = 1'b1;
        @(negedge clk) cal_req_i = 1'b0;
        while (busy_o) begin
            if (done_o) n_done++;
            if (ser_vld_o) n_ser++;
            @(negedge clk);
        end
        check("R6 calibration code", int'(dac_code_o), exp_code);
        check("R6 no done in calibration", n_done + n_ser, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset idle", int'({int_rst_o, int_en_o, dis_en_o, done_o, busy_o, ser_o, ser_vld_o, ovf_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset result", int'(result_o), 0);
        check("R8 reset dac", int'(dac_code_o), 0);

        // normal conversions with code 0 and offset chosen so t maps directly
        off = -MIDV;
        convert(0, 1'b0);
        convert(1, 1'b0);
        convert(300, 1'b1);

        calibrate(0);
        for (int t = 2; t < FULLV; t += 13) convert(t, 1'b0);
        convert(FULLV - 1, 1'b0);
        convert(FULLV, 1'b0);
        convert(FULLV + 1, 1'b0);
        convert(FULLV + 60, 1'b0);

        calibrate(-300);
        calibrate(-HALFDAC);
        calibrate(-1);
        calibrate(100);
        calibrate(HALFDAC - 1);
        calibrate(300);
        calibrate(37);
        convert(MIDV, 1'b0);
        convert(FULLV, 1'b1);

        finish_run();
    end

    initial begin
        wait (cyc >= 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        finish_run();
    end
endmodule